// File: doc/BRIEF.md
# Four-Phase Bus-to-Device Handshake Controller

This block sequences single data transfers between a bus master and a slave device. Both sides use four-phase, return-to-zero handshakes. The bus starts a transfer by raising either a read strobe, which moves data from the device onto the bus, or a write strobe, which moves data from the bus into the device. The controller answers the bus with a bus acknowledge. Toward the device it raises a request and waits for the device acknowledge. It also drives the enable of the transceiver that joins the two data paths.

The two directions use different event orders. A read requests the device first and opens the transceiver only once the device has answered. A write opens the transceiver first, then requests the device. When the device answers a write, the transceiver is closed before the bus is told the transfer is complete.

The controller is a clocked state machine. All three asynchronous inputs pass through a synchroniser, and the state register drives the outputs directly. Every state change produces one output event. The one exception is the final release step, where the bus acknowledge and the device request fall together. One hidden phase bit separates states whose output levels would otherwise be identical in read and write. A sticky flag records protocol violations.

Top module: `bus_xfer_ctrl`

## Requirements
- R1: After reset, the transceiver enable, device request, bus acknowledge and error flag are all low.
- R2: In a read, the device request rises first. The transceiver enable rises only after the device acknowledge has been seen high, and the bus acknowledge rises one step after the transceiver enable.
- R3: When the read strobe falls after a read, the transceiver enable falls first. One step later, the bus acknowledge and the device request fall together.
- R4: In a write, the transceiver enable rises first and the device request rises in a later step.
- R5: In a write, the device acknowledge rising makes the transceiver enable fall while the device request stays high. The bus acknowledge rises one step after that.
- R6: When the write strobe falls after a write, the bus acknowledge and the device request fall together and all outputs are low.
- R7: In any clock cycle, at most one of the three handshake outputs changes. The only exception is the release step, where the bus acknowledge and the device request fall together with the transceiver enable unchanged.
- R8: The device request never rises while the synchronised device acknowledge is still high. A strobe that arrives in that case waits; a write may still open the transceiver.
- R9: If both strobes are seen high while idle, the error flag goes high and all handshake outputs stay low.
- R10: A device acknowledge rising edge seen while the device request is low sets the error flag. Once set, the flag stays high until reset.
- R11: An input edge reaches the outputs on the (SYNC_STAGES+1)-th rising clock edge after it arrives: SYNC_STAGES edges in the synchroniser, then one in the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_strobe | input | 1 | Bus read strobe, asynchronous |
| wr_strobe | input | 1 | Bus write strobe, asynchronous |
| dev_ack | input | 1 | Device acknowledge, asynchronous |
| xcvr_en | output | 1 | Transceiver enable |
| dev_req | output | 1 | Device request |
| bus_ack | output | 1 | Bus acknowledge |
| proto_err | output | 1 | Sticky protocol error flag |

## Verification
The bench builds the block with the default two-stage synchroniser. It sizes the delay line of its reference model from that same value, so the exact three-cycle input-to-output latency is compared on every clock. With that fixed latency in place, the bench can create the awkward orderings on purpose. These include a strobe that arrives while the device acknowledge from the previous transfer is still high, both strobes together, and an unsolicited device acknowledge. Each of these is checked against the model cycle by cycle.

// File: rtl/hs_pkg.sv
package hs_pkg;
  // State code bit positions: {phase, xcvr, req, bus}
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned BIT_BUS   = 0;
  localparam int unsigned BIT_REQ   = 1;
  localparam int unsigned BIT_XCVR  = 2;
  localparam int unsigned BIT_PHASE = 3;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t C_IDLE    = 4'b0000;
  localparam code_t C_RD_REQ  = 4'b0010;
  localparam code_t C_RD_OPEN = 4'b0110;
  localparam code_t C_RD_DONE = 4'b0111;
  localparam code_t C_RD_SHUT = 4'b0011;
  localparam code_t C_WR_OPEN = 4'b1100;
  localparam code_t C_WR_REQ  = 4'b1110;
  localparam code_t C_WR_ISO  = 4'b1010;
  localparam code_t C_WR_DONE = 4'b1011;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_n = q[STAGES-1];
endmodule

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (i == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = stg[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= src;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
  import hs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_s,
  input  logic  wr_s,
  input  logic  ack_s,
  output code_t code,
  output logic  err
);
  code_t code_q, code_nxt;
  logic  err_q, err_set;
  logic  ack_d_q;
  logic  step_en, err_en;
  logic  both_idle, ack_rise;

  assign both_idle = (code_q == C_IDLE) && rd_s && wr_s;
  assign ack_rise  = ack_s && !ack_d_q;
  assign err_set   = both_idle || (ack_rise && !code_q[BIT_REQ]);

  always_comb begin
    code_nxt = code_q;
    case (code_q)
      C_IDLE: begin
        if (rd_s && wr_s)        code_nxt = C_IDLE;
        else if (rd_s && !ack_s) code_nxt = C_RD_REQ;
        else if (wr_s)           code_nxt = C_WR_OPEN;
      end
      C_RD_REQ:  if (ack_s)  code_nxt = C_RD_OPEN;
      C_RD_OPEN:             code_nxt = C_RD_DONE;
      C_RD_DONE: if (!rd_s)  code_nxt = C_RD_SHUT;
      C_RD_SHUT:             code_nxt = C_IDLE;
      C_WR_OPEN: if (!ack_s) code_nxt = C_WR_REQ;
      C_WR_REQ:  if (ack_s)  code_nxt = C_WR_ISO;
      C_WR_ISO:              code_nxt = C_WR_DONE;
      C_WR_DONE: if (!wr_s)  code_nxt = C_IDLE;
      default:               code_nxt = C_IDLE;
    endcase
  end

  assign step_en = (code_nxt != code_q);
  assign err_en  = err_set && !err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= C_IDLE;
    else if (step_en) code_q <= code_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_d_q <= 1'b0;
    else        ack_d_q <= ack_s;
  end

  assign code = code_q;
  assign err  = err_q;
endmodule

// File: rtl/bus_xfer_ctrl.sv
module bus_xfer_ctrl
  import hs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_strobe,
  input  logic wr_strobe,
  input  logic dev_ack,
  output logic xcvr_en,
  output logic dev_req,
  output logic bus_ack,
  output logic proto_err
);
  localparam int unsigned IN_W = 3;

  logic            rst_sync_n;
  logic [IN_W-1:0] raw_in, sync_in;
  logic            rd_s, wr_s, ack_s;
  code_t           code;

  rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n  (rst_sync_n)
  );

  assign raw_in = {rd_strobe, wr_strobe, dev_ack};

  bit_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (raw_in),
    .q     (sync_in)
  );

  assign {rd_s, wr_s, ack_s} = sync_in;

  xfer_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .rd_s  (rd_s),
    .wr_s  (wr_s),
    .ack_s (ack_s),
    .code  (code),
    .err   (proto_err)
  );

  assign xcvr_en = code[BIT_XCVR];
  assign dev_req = code[BIT_REQ];
  assign bus_ack = code[BIT_BUS];
endmodule

// File: rtl/bus_xfer_ctrl_chk.sv
module bus_xfer_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_s,
  input logic wr_s,
  input logic ack_s,
  input logic xcvr_en,
  input logic dev_req,
  input logic bus_ack,
  input logic proto_err
);
  // R7
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({xcvr_en ^ $past(xcvr_en), dev_req ^ $past(dev_req),
                 bus_ack ^ $past(bus_ack)}) <= 1)
    || ($fell(dev_req) && $fell(bus_ack) && $stable(xcvr_en)));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_req) |-> !$past(ack_s));

  // R2
  rd_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(xcvr_en) && $past(dev_req)) |-> $past(ack_s));

  // R5
  wr_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(xcvr_en) && dev_req && !bus_ack) |-> $past(ack_s));

  // R3
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack) |-> (!dev_req && !xcvr_en));

  // R9
  dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_s && wr_s && !xcvr_en && !dev_req && !bus_ack)
    |=> (proto_err && !xcvr_en && !dev_req && !bus_ack));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
endmodule

bind bus_xfer_ctrl bus_xfer_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .rd_s      (rd_s),
  .wr_s      (wr_s),
  .ack_s     (ack_s),
  .xcvr_en   (xcvr_en),
  .dev_req   (dev_req),
  .bus_ack   (bus_ack),
  .proto_err (proto_err)
);

// File: tb/sim_bus_xfer_ctrl.sv
module sim_bus_xfer_ctrl;
  localparam int STG = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd = 1'b0, wr = 1'b0, ack = 1'b0;
  logic xcvr_en, dev_req, bus_ack, proto_err;

  always #5 clk = ~clk;

  bus_xfer_ctrl #(.SYNC_STAGES(STG)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd), .wr_strobe(wr), .dev_ack(ack),
    .xcvr_en(xcvr_en), .dev_req(dev_req), .bus_ack(bus_ack), .proto_err(proto_err)
  );

  int checks = 0, failures = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: transfer mode, step in sequence, input delay lines
  int m_mode = 0, m_step = 0;
  bit m_err = 0, m_ack_d = 0;
  bit rq[$], wq[$], aq[$];

  function automatic logic [2:0] m_out(); // {xcvr, req, bus}
    if (m_mode == 1)
      case (m_step)
        1: return 3'b010; 2: return 3'b110; 3: return 3'b111; 4: return 3'b011;
        default: return 3'b000;
      endcase
    if (m_mode == 2)
      case (m_step)
        1: return 3'b100; 2: return 3'b110; 3: return 3'b010; 4: return 3'b011;
        default: return 3'b000;
      endcase
    return 3'b000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_step = 0; m_err = 0; m_ack_d = 0;
      rq = {}; wq = {}; aq = {};
      for (int i = 0; i < STG; i++) begin rq.push_back(0); wq.push_back(0); aq.push_back(0); end
    end else begin
      bit s_rd, s_wr, s_ack, lds;
      s_rd = rq[0]; s_wr = wq[0]; s_ack = aq[0];
      lds = m_out()[1];
      if (s_ack && !m_ack_d && !lds) m_err = 1;
      case (m_mode)
        0: if (s_rd && s_wr) m_err = 1;
           else if (s_rd && !s_ack) begin m_mode = 1; m_step = 1; end
           else if (s_wr) begin m_mode = 2; m_step = 1; end
        1: case (m_step)
             1: if (s_ack) m_step = 2;
             2: m_step = 3;
             3: if (!s_rd) m_step = 4;
             default: begin m_mode = 0; m_step = 0; end
           endcase
        default: case (m_step)
             1: if (!s_ack) m_step = 2;
             2: if (s_ack) m_step = 3;
             3: m_step = 4;
             default: if (!s_wr) begin m_mode = 0; m_step = 0; end
           endcase
      endcase
      m_ack_d = s_ack;
      void'(rq.pop_front()); void'(wq.pop_front()); void'(aq.pop_front());
      rq.push_back(rd); wq.push_back(wr); aq.push_back(ack);
    end
  end

  // Per-cycle comparison, away from the active edge
  logic [2:0] prev_o = 3'b000;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] cur, ex;
      cur = {xcvr_en, dev_req, bus_ack};
      ex  = m_out();
      chk(cur === ex, "R11 outputs vs model", int'(cur), int'(ex));
      chk(proto_err === m_err, "R10 error vs model", int'(proto_err), int'(m_err));
      if (cur !== prev_o)
        chk(($countones(cur ^ prev_o) <= 1) ||
            (prev_o[1:0] == 2'b11 && cur[1:0] == 2'b00 && cur[2] == prev_o[2]),
            "R7 single event", int'(cur), int'(prev_o));
      prev_o = cur;
    end else prev_o = 3'b000;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic sig(input int sel);
    case (sel)
      0: return xcvr_en; 1: return dev_req; default: return bus_ack;
    endcase
  endfunction

  task automatic wait_for(input int sel, input logic val, input string tag);
    int n = 0;
    while (sig(sel) !== val && n < 60) begin @(negedge clk); n++; end
    if (n >= 60) chk(1'b0, tag, int'(sig(sel)), int'(val));
  endtask

  localparam int XC = 0, RQ = 1, BA = 2;

  task automatic do_reset();
    rst_n = 1'b0; repeat (3) @(negedge clk);
    rst_n = 1'b1; repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1; repeat (4) @(negedge clk);
    // R1
    chk({xcvr_en, dev_req, bus_ack, proto_err} == 4'b0, "R1 reset outputs",
        int'({xcvr_en, dev_req, bus_ack, proto_err}), 0);

    // R11 latency, then R2 read launch
    rd = 1'b1;
    repeat (2) @(negedge clk);
    chk(dev_req == 1'b0, "R11 req not before third edge", int'(dev_req), 0);
    @(negedge clk);
    chk(dev_req == 1'b1, "R11 req on third edge", int'(dev_req), 1);
    repeat (6) @(negedge clk);
    chk(xcvr_en == 1'b0, "R2 xcvr waits for ack", int'(xcvr_en), 0);
    ack = 1'b1;
    wait_for(XC, 1'b1, "R2 xcvr open");
    chk(dev_req && !bus_ack, "R2 open before bus ack", int'({dev_req, bus_ack}), 2);
    wait_for(BA, 1'b1, "R2 bus ack");
    chk(xcvr_en == 1'b1, "R2 bus ack with xcvr", int'(xcvr_en), 1);
    // R3 read release
    rd = 1'b0;
    wait_for(XC, 1'b0, "R3 xcvr close");
    chk(bus_ack && dev_req, "R3 xcvr falls first", int'({dev_req, bus_ack}), 3);
    wait_for(BA, 1'b0, "R3 bus ack fall");
    chk(dev_req == 1'b0, "R3 req falls with bus ack", int'(dev_req), 0);

    // R8 new read while device ack still high
    rd = 1'b1;
    repeat (8) @(negedge clk);
    chk(dev_req == 1'b0, "R8 req held while ack high", int'(dev_req), 0);
    ack = 1'b0;
    wait_for(RQ, 1'b1, "R8 req after ack low");
    ack = 1'b1;
    wait_for(BA, 1'b1, "R2 second read ack");
    rd = 1'b0;
    wait_for(BA, 1'b0, "R3 second read release");
    ack = 1'b0;
    repeat (6) @(negedge clk);

    // R4 write launch
    wr = 1'b1;
    wait_for(XC, 1'b1, "R4 xcvr first");
    chk(dev_req == 1'b0, "R4 req after xcvr", int'(dev_req), 0);
    wait_for(RQ, 1'b1, "R4 req");
    chk(xcvr_en == 1'b1, "R4 xcvr held with req", int'(xcvr_en), 1);
    repeat (4) @(negedge clk);
    chk(!bus_ack && xcvr_en, "R5 waiting for device", int'({xcvr_en, bus_ack}), 2);
    // R5 isolate then acknowledge
    ack = 1'b1;
    wait_for(XC, 1'b0, "R5 isolate");
    chk(dev_req && !bus_ack, "R5 isolate before bus ack", int'({dev_req, bus_ack}), 2);
    wait_for(BA, 1'b1, "R5 bus ack");
    chk(xcvr_en == 1'b0, "R5 xcvr closed at bus ack", int'(xcvr_en), 0);
    // R6 write release
    wr = 1'b0;
    wait_for(BA, 1'b0, "R6 release");
    chk(!dev_req && !xcvr_en, "R6 all low", int'({xcvr_en, dev_req}), 0);

    // R8 write while ack still high
    wr = 1'b1;
    wait_for(XC, 1'b1, "R8 write opens");
    repeat (6) @(negedge clk);
    chk(dev_req == 1'b0, "R8 write req held", int'(dev_req), 0);
    ack = 1'b0;
    wait_for(RQ, 1'b1, "R8 write req after ack low");
    ack = 1'b1;
    wait_for(BA, 1'b1, "R5 second write ack");
    wr = 1'b0;
    wait_for(BA, 1'b0, "R6 second write release");
    ack = 1'b0;
    repeat (6) @(negedge clk);
    chk(proto_err == 1'b0, "R10 no error on legal traffic", int'(proto_err), 0);

    // R9 both strobes
    rd = 1'b1; wr = 1'b1;
    repeat (8) @(negedge clk);
    chk(proto_err == 1'b1, "R9 error set", int'(proto_err), 1);
    chk({xcvr_en, dev_req, bus_ack} == 3'b0, "R9 held idle",
        int'({xcvr_en, dev_req, bus_ack}), 0);
    rd = 1'b0; wr = 1'b0;
    repeat (4) @(negedge clk);
    chk(proto_err == 1'b1, "R10 flag sticky", int'(proto_err), 1);
    do_reset();
    chk(proto_err == 1'b0, "R1 reset clears error", int'(proto_err), 0);

    // R10 unsolicited device acknowledge
    ack = 1'b1;
    repeat (6) @(negedge clk);
    chk(proto_err == 1'b1, "R10 ack without req", int'(proto_err), 1);
    chk(dev_req == 1'b0, "R10 no request raised", int'(dev_req), 0);
    ack = 1'b0;
    repeat (4) @(negedge clk);
    chk(proto_err == 1'b1, "R10 sticky after ack low", int'(proto_err), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule